// File: doc/BRIEF.md
# Open-Page DRAM Read Sequencer

This block turns single read requests, each naming a bank, a row and a column, into the command stream for a plain DRAM command port. It keeps a row open after every access. It also keeps a small table that records, for each bank, whether a row is open and which row it is. On each request it takes one of three paths:

- If the requested row is already open, it issues a column read only.
- If the bank has no open row, it activates the row and then reads.
- If a different row is open in that bank, it closes that row, opens the requested one, and then reads.

The page timings are run-time settings counted in memory clocks: the column latency, the row-to-column delay, the precharge time and the minimum row-active time. Every command can be held on the port for one clock or for two, to suit a slow command bus.

The sequencer handles one request at a time. A ready/valid handshake takes a request only while the block is idle. It signals the cycle in which the first read beat is due, keeps a window high for as long as the burst lasts, and reports the burst length in beats. A timing setting of zero behaves as one.

Top module: `pgseq_top`

## Requirements
- R1: After reset, req_ready is high, cmd_valid, data_start and data_window are low, and every bank is treated as having no open row.
- R2: A request whose row matches the open row of its bank produces only a read command (cmd_op 3), first driven in the cycle after acceptance.
- R3: A request to a bank with no open row produces an activate (cmd_op 2) first driven in the cycle after acceptance, then a read, with no precharge.
- R4: A request to a bank holding a different open row produces a precharge (cmd_op 1), then an activate, then a read, in that order.
- R5: An activate that follows a precharge is first driven exactly cfg_trp cycles after the cycle in which the precharge was issued.
- R6: A read that follows an activate is first driven exactly cfg_trcd cycles after the cycle in which the activate was issued.
- R7: A precharge is first driven in the later of two cycles: the cycle after acceptance, or cfg_tras cycles after the issue cycle of the last activate to that bank.
- R8: data_start is a one-cycle pulse exactly cfg_cl cycles after the cycle in which the read was issued.
- R9: With cfg_two_t high, every command is driven for exactly two consecutive cycles and cmd_issue is high on the second. With it low, each command is driven for one cycle with cmd_issue high.
- R10: req_ready is low from the cycle after acceptance through the data_start cycle, and high again in the next cycle. A request presented while req_ready is low has no effect.
- R11: data_beats equals the burst length (4 by default). data_window is high for burst length / 2 cycles, starting in the data_start cycle.
- R12: While cmd_valid is high, cmd_bank carries the request's bank. cmd_row carries its row during an activate, and cmd_col carries its column during a read. When nothing is driven, cmd_op is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cl | input | T_W | Column latency in cycles |
| cfg_trcd | input | T_W | Activate-to-read delay in cycles |
| cfg_trp | input | T_W | Precharge-to-activate delay in cycles |
| cfg_tras | input | T_W | Minimum activate-to-precharge time in cycles |
| cfg_two_t | input | 1 | 1: hold each command two clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_bank | input | log2(NUM_BANKS) | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| cmd_valid | output | 1 | Command driven this cycle |
| cmd_issue | output | 1 | Command counts as issued this cycle |
| cmd_op | output | 2 | 0 none, 1 precharge, 2 activate, 3 read |
| cmd_bank | output | log2(NUM_BANKS) | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |
| data_start | output | 1 | First read beat due this cycle |
| data_window | output | 1 | Burst in progress |
| data_beats | output | log2(BURST_LEN+1) | Beats per burst |

## Verification
The bench builds the block with its defaults: four banks, 4-bit rows, columns and timing fields, and a burst of four beats. This small setup allows a full cross of CL 1 to 3, tRCD 1 to 3, tRP 1 and 3, tRAS 1, 6 and 15, and both command rates. In every setting, eight requests take the hit, closed-bank and conflict paths on several banks. With tRAS 15 a conflict arrives while the old row is still too young to close, which tests the activate-age wait. With tRAS 1 the same conflict goes straight through. During every busy stretch the bench also presents unrelated requests, to show that they are dropped.

// File: rtl/pgseq_pkg.sv
// Shared types for the open-page read sequencer.
// Assumes: command code values are fixed by the command port.
package pgseq_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_PRE = 2'd1,
        OP_ACT = 2'd2,
        OP_RD  = 2'd3
    } pg_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ACT  = 3'd2,
        ST_RD   = 3'd3,
        ST_DATA = 3'd4
    } pg_state_e;

endpackage

// File: rtl/pgseq_downcnt.sv
// Loadable down counter that stops at zero. It is used for every timing
// interval in the sequencer.
// Assumes: load takes priority over counting; reset leaves it expired.
module pgseq_downcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load a fresh interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgseq_bank_table.sv
// Per-bank open-row table. For each bank it holds the open flag, the open
// row and an activate-age counter. It answers lookups for a single bank.
// Assumes: activate and precharge never target the same bank in one cycle.
module pgseq_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 4,
    parameter int T_W       = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    output logic              look_open,
    output logic              look_hit,
    output logic              look_ras_ok,
    input  logic              act_en,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic [T_W-1:0]    act_ras_val,
    input  logic              pre_en,
    input  logic [BANK_W-1:0] pre_bank
);

    logic                 open_q [NUM_BANKS];
    logic [ROW_W-1:0]     row_q  [NUM_BANKS];
    logic [NUM_BANKS-1:0] ras_zero;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel_act;
        logic sel_pre;
        assign sel_act = act_en && (act_bank == BANK_W'(g));
        assign sel_pre = pre_en && (pre_bank == BANK_W'(g));

        // Record an opened row and clear the flag when the row closes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[g] <= 1'b0;
                row_q[g]  <= '0;
            end else if (sel_act) begin
                open_q[g] <= 1'b1;
                row_q[g]  <= act_row;
            end else if (sel_pre) begin
                open_q[g] <= 1'b0;
            end
        end

        pgseq_downcnt #(.W(T_W)) u_ras (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (sel_act),
            .load_val (act_ras_val),
            .zero     (ras_zero[g])
        );
    end

    // Look up the addressed bank.
    always_comb begin
        look_open   = open_q[look_bank];
        look_hit    = open_q[look_bank] && (row_q[look_bank] == look_row);
        look_ras_ok = ras_zero[look_bank];
    end

endmodule

// File: rtl/pgseq_burst.sv
// Burst window generator. From a start pulse it raises a window that
// covers a double-data-rate burst, two beats per clock.
// Assumes: BURST_LEN is even and at least 2.
module pgseq_burst #(
    parameter int BURST_LEN = 4,
    localparam int SPAN     = BURST_LEN / 2,
    localparam int CW       = $clog2(SPAN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic window
);

    logic done;

    pgseq_downcnt #(.W(CW)) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (CW'(SPAN - 1)),
        .zero     (done)
    );

    // The window covers the start cycle and the cycles left in the count.
    assign window = start || !done;

endmodule

// File: rtl/pgseq_fsm.sv
// Command state machine. It picks the hit, closed or conflict path for a
// request, waits on the timing counters, holds each command for the set
// command rate and steps through precharge, activate, read and latency.
// Assumes: configuration stays stable while a request is in progress.
module pgseq_fsm
    import pgseq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int T_W       = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [T_W-1:0]    cfg_cl,
    input  logic [T_W-1:0]    cfg_trcd,
    input  logic [T_W-1:0]    cfg_trp,
    input  logic [T_W-1:0]    cfg_tras,
    input  logic              cfg_two_t,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              look_open,
    input  logic              look_hit,
    input  logic              ras_ok,
    input  logic              gap_zero,
    input  logic              lat_zero,
    output logic              req_ready,
    output logic              busy,
    output logic [BANK_W-1:0] cur_bank,
    output logic [ROW_W-1:0]  cur_row,
    output logic [COL_W-1:0]  cur_col,
    output logic              cmd_valid,
    output logic              cmd_issue,
    output logic [1:0]        cmd_op,
    output logic              gap_load,
    output logic [T_W-1:0]    gap_val,
    output logic              lat_load,
    output logic [T_W-1:0]    lat_val,
    output logic              act_en,
    output logic              pre_en,
    output logic [T_W-1:0]    ras_val,
    output logic              data_start
);

    pg_state_e state_q;
    logic      hold_q;
    logic      gate;
    logic [T_W-1:0] cl_m1, trcd_m1, trp_m1, tras_m1;

    // Turn each setting into a reload value; zero behaves as one.
    always_comb begin
        cl_m1   = (cfg_cl   == '0) ? '0 : cfg_cl   - 1'b1;
        trcd_m1 = (cfg_trcd == '0) ? '0 : cfg_trcd - 1'b1;
        trp_m1  = (cfg_trp  == '0) ? '0 : cfg_trp  - 1'b1;
        tras_m1 = (cfg_tras == '0) ? '0 : cfg_tras - 1'b1;
    end

    // Decide whether the pending command may be on the port this cycle.
    always_comb begin
        unique case (state_q)
            ST_PRE:        gate = gap_zero && ras_ok;
            ST_ACT, ST_RD: gate = gap_zero;
            default:       gate = 1'b0;
        endcase
    end

    // Drive the command port and the counter loads.
    always_comb begin
        cmd_valid  = gate;
        cmd_issue  = gate && (!cfg_two_t || hold_q);
        cmd_op     = OP_NOP;
        if (gate) begin
            unique case (state_q)
                ST_PRE:  cmd_op = OP_PRE;
                ST_ACT:  cmd_op = OP_ACT;
                default: cmd_op = OP_RD;
            endcase
        end
        gap_load   = cmd_issue && ((state_q == ST_PRE) || (state_q == ST_ACT));
        gap_val    = (state_q == ST_PRE) ? trp_m1 : trcd_m1;
        lat_load   = cmd_issue && (state_q == ST_RD);
        lat_val    = cl_m1;
        act_en     = cmd_issue && (state_q == ST_ACT);
        pre_en     = cmd_issue && (state_q == ST_PRE);
        ras_val    = tras_m1;
        data_start = (state_q == ST_DATA) && lat_zero;
        req_ready  = (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
    end

    // Track the first cycle of a two-clock command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (cmd_issue) begin
            hold_q <= 1'b0;
        end else if (gate && cfg_two_t) begin
            hold_q <= 1'b1;
        end
    end

    // Step through the command sequence of one request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_bank <= '0;
            cur_row  <= '0;
            cur_col  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_bank <= req_bank;
                        cur_row  <= req_row;
                        cur_col  <= req_col;
                        if (look_hit)       state_q <= ST_RD;
                        else if (look_open) state_q <= ST_PRE;
                        else                state_q <= ST_ACT;
                    end
                end
                ST_PRE:  if (cmd_issue) state_q <= ST_ACT;
                ST_ACT:  if (cmd_issue) state_q <= ST_RD;
                ST_RD:   if (cmd_issue) state_q <= ST_DATA;
                ST_DATA: if (lat_zero)  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgseq_top.sv
// Open-page DRAM read sequencer, top level. It ties the bank table, the
// command state machine, the gap and latency counters and the burst
// window together.
// Assumes: one request at a time; configuration changes only while idle.
module pgseq_top #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int T_W       = 4,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int BEAT_W   = $clog2(BURST_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [T_W-1:0]    cfg_cl,
    input  logic [T_W-1:0]    cfg_trcd,
    input  logic [T_W-1:0]    cfg_trp,
    input  logic [T_W-1:0]    cfg_tras,
    input  logic              cfg_two_t,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              cmd_valid,
    output logic              cmd_issue,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              data_start,
    output logic              data_window,
    output logic [BEAT_W-1:0] data_beats
);

    logic              busy;
    logic [BANK_W-1:0] cur_bank;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [BANK_W-1:0] look_bank;
    logic [ROW_W-1:0]  look_row;
    logic              look_open, look_hit, look_ras_ok;
    logic              gap_load, gap_zero, lat_load, lat_zero;
    logic [T_W-1:0]    gap_val, lat_val, ras_val;
    logic              act_en, pre_en;

    // Look up the incoming request while idle, the held one while busy.
    assign look_bank = busy ? cur_bank : req_bank;
    assign look_row  = busy ? cur_row  : req_row;

    pgseq_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .T_W       (T_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_bank   (look_bank),
        .look_row    (look_row),
        .look_open   (look_open),
        .look_hit    (look_hit),
        .look_ras_ok (look_ras_ok),
        .act_en      (act_en),
        .act_bank    (cur_bank),
        .act_row     (cur_row),
        .act_ras_val (ras_val),
        .pre_en      (pre_en),
        .pre_bank    (cur_bank)
    );

    pgseq_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .T_W       (T_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_cl     (cfg_cl),
        .cfg_trcd   (cfg_trcd),
        .cfg_trp    (cfg_trp),
        .cfg_tras   (cfg_tras),
        .cfg_two_t  (cfg_two_t),
        .req_valid  (req_valid),
        .req_bank   (req_bank),
        .req_row    (req_row),
        .req_col    (req_col),
        .look_open  (look_open),
        .look_hit   (look_hit),
        .ras_ok     (look_ras_ok),
        .gap_zero   (gap_zero),
        .lat_zero   (lat_zero),
        .req_ready  (req_ready),
        .busy       (busy),
        .cur_bank   (cur_bank),
        .cur_row    (cur_row),
        .cur_col    (cur_col),
        .cmd_valid  (cmd_valid),
        .cmd_issue  (cmd_issue),
        .cmd_op     (cmd_op),
        .gap_load   (gap_load),
        .gap_val    (gap_val),
        .lat_load   (lat_load),
        .lat_val    (lat_val),
        .act_en     (act_en),
        .pre_en     (pre_en),
        .ras_val    (ras_val),
        .data_start (data_start)
    );

    pgseq_downcnt #(.W(T_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    pgseq_downcnt #(.W(T_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_val (lat_val),
        .zero     (lat_zero)
    );

    pgseq_burst #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (data_start),
        .window (data_window)
    );

    // Present the command fields of the request in progress.
    assign cmd_bank   = cur_bank;
    assign cmd_row    = cur_row;
    assign cmd_col    = cur_col;
    assign data_beats = BEAT_W'(BURST_LEN);

endmodule

// File: rtl/pgseq_checker.sv
// Protocol checker for the sequencer. It keeps its own age counters per
// bank and since the last precharge, and checks the timing and hold rules
// at the top-level ports.
// Assumes: bound to pgseq_top; settings stable outside reset while busy.
module pgseq_checker #(
    parameter int NUM_BANKS = 4,
    parameter int T_W       = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SW       = T_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [T_W-1:0]    cfg_trp,
    input logic [T_W-1:0]    cfg_tras,
    input logic              cfg_two_t,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_issue,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              data_start
);

    logic [SW-1:0] since_act [NUM_BANKS];
    logic [SW-1:0] since_pre;
    logic [SW-1:0] trp_eff, tras_eff, sel_act_age;

    assign trp_eff     = (cfg_trp  == '0) ? SW'(1) : {1'b0, cfg_trp};
    assign tras_eff    = (cfg_tras == '0) ? SW'(1) : {1'b0, cfg_tras};
    assign sel_act_age = since_act[cmd_bank];

    // Age of the last activate per bank, saturating.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (!rst_n) begin
                since_act[i] <= '1;
            end else if (cmd_issue && cmd_op == 2'd2 && cmd_bank == BANK_W'(i)) begin
                since_act[i] <= SW'(1);
            end else if (since_act[i] != '1) begin
                since_act[i] <= since_act[i] + 1'b1;
            end
        end
    end

    // Age of the last precharge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= '1;
        end else if (cmd_issue && cmd_op == 2'd1) begin
            since_pre <= SW'(1);
        end else if (since_pre != '1) begin
            since_pre <= since_pre + 1'b1;
        end
    end

    a_r9_two_clock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_two_t && cmd_valid && !cmd_issue |=>
            cmd_valid && cmd_issue && $stable(cmd_op) && $stable(cmd_bank));

    a_r9_one_clock_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_two_t && cmd_valid |-> cmd_issue);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid && !data_start);

    a_r7_row_age: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd1 |-> sel_act_age >= tras_eff);

    a_r5_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd2 |-> since_pre >= trp_eff);

endmodule

bind pgseq_top pgseq_checker #(
    .NUM_BANKS (NUM_BANKS),
    .T_W       (T_W)
) u_pgseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_trp    (cfg_trp),
    .cfg_tras   (cfg_tras),
    .cfg_two_t  (cfg_two_t),
    .req_ready  (req_ready),
    .cmd_valid  (cmd_valid),
    .cmd_issue  (cmd_issue),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .data_start (data_start)
);

// File: tb/sim_pgseq_top.sv
// Sweep bench for the open-page sequencer: computes every command cycle
// arithmetically from the settings and compares at the ports.
module sim_pgseq_top;
    localparam int NB = 4, RW = 4, CW = 4, TW = 4, BL = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [TW-1:0] cfg_cl, cfg_trcd, cfg_trp, cfg_tras;
    logic          cfg_two_t;
    logic          req_valid, req_ready;
    logic [1:0]    req_bank;
    logic [RW-1:0] req_row;
    logic [CW-1:0] req_col;
    logic          cmd_valid, cmd_issue;
    logic [1:0]    cmd_op, cmd_bank;
    logic [RW-1:0] cmd_row;
    logic [CW-1:0] cmd_col;
    logic          data_start, data_window;
    logic [2:0]    data_beats;

    pgseq_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd),
        .cfg_trp(cfg_trp), .cfg_tras(cfg_tras), .cfg_two_t(cfg_two_t),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .cmd_valid(cmd_valid),
        .cmd_issue(cmd_issue), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .data_start(data_start),
        .data_window(data_window), .data_beats(data_beats)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_open [NB];
    int m_row  [NB];
    int m_act  [NB];
    int v_cl, v_trcd, v_trp, v_tras, v_h;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle, quiet port after reset
        chk(req_ready && !cmd_valid && !data_start && !data_window, "R1 reset state",
            {req_ready, cmd_valid, data_start, data_window}, 4'b1000);
        // R11: beat count
        chk(data_beats == BL, "R11 beat count", data_beats, BL);
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 0;
            m_act[i]  = -1000;
        end
    endtask

    task automatic do_req(input int b, input int r, input int c);
        int t0, kind, pre_s, act_s, act_i, rd_s, rd_i, dat, o, ds;
        int os [4];
        int oi [4];
        int vc [4];
        int bad_addr, bad_win, bad_ready, exp_mask, obs_mask;
        string ptag;
        bad_addr = 0; bad_win = 0; bad_ready = 0; ds = -1;
        for (int i = 0; i < 4; i++) begin os[i] = -1; oi[i] = -1; vc[i] = 0; end
        while (!req_ready) @(negedge clk);
        t0 = cyc;
        req_valid = 1'b1;
        req_bank = 2'(b); req_row = RW'(r); req_col = CW'(c);
        pre_s = -1; act_s = -1; act_i = -1;
        if (m_open[b] && m_row[b] == r) begin
            kind = 0; rd_s = t0 + 1;
        end else begin
            if (m_open[b]) begin
                kind = 2;
                pre_s = (t0 + 1 > m_act[b] + v_tras) ? t0 + 1 : m_act[b] + v_tras;
                act_s = pre_s + v_h - 1 + v_trp;
            end else begin
                kind = 1; act_s = t0 + 1;
            end
            act_i = act_s + v_h - 1;
            rd_s  = act_i + v_trcd;
        end
        rd_i = rd_s + v_h - 1;
        dat  = rd_i + v_cl;
        @(negedge clk);
        for (int cc = t0 + 1; cc <= dat + 1; cc++) begin
            if (cmd_valid) begin
                o = int'(cmd_op);
                vc[o]++;
                if (os[o] < 0) os[o] = cc;
                if (cmd_issue && oi[o] < 0) oi[o] = cc;
                if (int'(cmd_bank) != b) bad_addr++;
                if (o == 2 && int'(cmd_row) != r) bad_addr++;
                if (o == 3 && int'(cmd_col) != c) bad_addr++;
            end
            if (data_start && ds < 0) ds = cc;
            if (data_window != (cc >= dat)) bad_win++;
            if (req_ready != (cc == dat + 1)) bad_ready++;
            // unrelated request while busy: must be ignored (R10)
            if (cc <= dat) begin
                req_valid = 1'b1;
                req_bank = 2'((b + 1) % NB); req_row = RW'(15 - r); req_col = CW'(3);
            end else begin
                req_valid = 1'b0;
            end
            if (cc < dat + 1) @(negedge clk);
        end
        exp_mask = (kind == 0) ? 4'b1000 : (kind == 1) ? 4'b1100 : 4'b1110;
        obs_mask = 0;
        for (int i = 0; i < 4; i++) if (os[i] >= 0) obs_mask |= (1 << i);
        ptag = (kind == 0) ? "R2 hit command set" :
               (kind == 1) ? "R3 closed-bank command set" : "R4 conflict command set";
        chk(obs_mask == exp_mask, ptag, obs_mask, exp_mask);
        if (kind == 2) begin
            chk(os[1] == pre_s, "R7 precharge start", os[1], pre_s);
            chk(os[2] == act_s, "R5 activate after precharge", os[2], act_s);
        end
        if (kind == 1) chk(os[2] == act_s, "R3 activate start", os[2], act_s);
        chk(os[3] == rd_s, (kind == 0) ? "R2 read start" : "R6 read after activate", os[3], rd_s);
        for (int i = 1; i < 4; i++) begin
            if ((exp_mask >> i) & 1)
                chk(oi[i] == os[i] + v_h - 1 && vc[i] == v_h, "R9 command hold", vc[i], v_h);
        end
        chk(ds == dat, "R8 data start", ds, dat);
        chk(bad_win == 0, "R11 burst window", bad_win, 0);
        chk(bad_ready == 0, "R10 ready timing", bad_ready, 0);
        chk(bad_addr == 0, "R12 command fields", bad_addr, 0);
        if (kind != 0) begin
            m_open[b] = 1; m_row[b] = r; m_act[b] = act_i;
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
        cfg_cl = 1; cfg_trcd = 1; cfg_trp = 1; cfg_tras = 1; cfg_two_t = 0;
        @(negedge clk);
        for (int a = 1; a <= 3; a++)
        for (int d = 1; d <= 3; d++)
        for (int p = 0; p < 2; p++)
        for (int s = 0; s < 3; s++)
        for (int t = 0; t < 2; t++) begin
            v_cl = a; v_trcd = d; v_trp = (p == 0) ? 1 : 3;
            v_tras = (s == 0) ? 1 : (s == 1) ? 6 : 15;
            v_h = t + 1;
            cfg_cl = TW'(v_cl); cfg_trcd = TW'(v_trcd); cfg_trp = TW'(v_trp);
            cfg_tras = TW'(v_tras); cfg_two_t = (t == 1);
            do_reset();
            do_req(0, 1, 2);
            do_req(0, 1, 5);
            do_req(0, 3, 1);
            do_req(1, 3, 4);
            do_req(0, 3, 7);
            do_req(1, 4, 0);
            do_req(2, 0, 9);
            do_req(0, 0, 15);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule